// File: doc/BRIEF.md
# Dual Complex Adder-Accumulator

This block is a two-lane arithmetic datapath for complex data. One lane handles the real part and the other the imaginary part. Each lane owns a 20-bit adder/subtractor and an accumulator register. Two 16-bit two's-complement ports, A and B, are captured in input registers. Each input register has its own active-low load enable. Captured values are sign-extended to 20 bits before any arithmetic.

The real lane's primary operand comes from a source-select mux. That mux picks either the A register or the A register delayed through an 8-stage deskew line. The deskew line aligns data that bypassed an external multiplier in FFT butterflies. The imaginary lane's primary operand is the B register. A shared feedback select replaces each lane's primary operand with that lane's own accumulator, which turns both lanes into accumulators for complex filtering. The secondary operand is B for the real lane and A for the imaginary lane.

Every control input is captured on the rising clock edge together with the data. A control change therefore lands on the accumulators one edge after it is captured, the same edge as the data captured alongside it. The two raw 20-bit accumulators and a per-lane wrap flag are the outputs. Two output-enable inputs pass straight through for use by an external driver stage.

Top module: `cplx_accum_dual`

## Requirements
- R1: After reset both accumulators read 0, both overflow flags are low, and the deskew line holds zeros.
- R2: The 2-bit lane operation code selects the operation: 00 gives P+Q, 01 passes P, 10 gives P-Q, 11 gives Q-P. P is the primary operand and Q the secondary operand; the result is written to the lane's accumulator.
- R3: A lane's overflow flag is registered with its accumulator. It is high exactly when the true result of that lane's operation does not fit in 20-bit two's complement. The pass operation never raises it.
- R4: The two lanes take separate operation codes. For the real lane, Q is the B register. For the imaginary lane, P is the B register and Q is the A register.
- R5: When the shared feedback select is high, each lane's P is its own accumulator instead of fresh data.
- R6: When the delay select is high and feedback is low, the real lane's P is the A register value from 8 clock edges earlier. The deskew line shifts on every edge regardless of the A load enable.
- R7: The shared clear sets both accumulators to 0 and both overflow flags low, and it takes priority over every operation.
- R8: Operation codes, feedback select, delay select and clear are registered. A value present before edge k acts on the accumulators at edge k+1, together with the port data captured at edge k.
- R9: The A and B registers load only on edges where their active-low enable is low; otherwise they keep their value.
- R10: 16-bit inputs are treated as two's complement and sign-extended to 20 bits.
- R11: Each output-enable input appears unchanged and combinationally on its matching output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | 16 | Port A data, two's complement |
| b_in | input | 16 | Port B data, two's complement |
| a_load_n | input | 1 | Active-low load enable of the A register |
| b_load_n | input | 1 | Active-low load enable of the B register |
| op_re | input | 2 | Real lane operation code |
| op_im | input | 2 | Imaginary lane operation code |
| fb_sel | input | 1 | High: both lanes use accumulator feedback as P |
| dly_sel | input | 1 | High: real lane uses the 8-edge delayed A value |
| acc_clr | input | 1 | Clears both accumulators |
| oe_re_n | input | 1 | Output enable for the real result, passed through |
| oe_im_n | input | 1 | Output enable for the imaginary result, passed through |
| acc_re | output | 20 | Real lane accumulator |
| acc_im | output | 20 | Imaginary lane accumulator |
| ovf_re | output | 1 | Real lane wrap flag |
| ovf_im | output | 1 | Imaginary lane wrap flag |
| oe_re_out_n | output | 1 | Pass-through of oe_re_n |
| oe_im_out_n | output | 1 | Pass-through of oe_im_n |

## Verification
The hardest case to reach from the ports is a 20-bit wrap. Fresh 16-bit operands can never overflow a 20-bit adder, so the wrap can only come from feedback. The stimulus holds feedback select high and keeps adding a full-scale positive B into the real accumulator, while the imaginary lane keeps subtracting a full-scale positive A. Both lanes therefore cross their range limits in opposite directions within about sixteen edges. A clear then follows and must wipe both flags. The deskew path is also checked straight after reset, before any non-zero data has entered it, to show that it starts at zero.

// File: rtl/cad_pkg.sv
package cad_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_PASS = 2'b01,
    OP_SUB  = 2'b10,
    OP_RSUB = 2'b11
  } lane_op_e;
endpackage

// File: rtl/cad_deskew.sv
module cad_deskew #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      logic [W-1:0] stg_d;
      if (k == 0) begin : g_head
        always_comb stg_d = din;
      end else begin : g_body
        always_comb stg_d = stg[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg_d;
      end
    end
  endgenerate

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/cad_lane.sv
module cad_lane
  import cad_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fb,
  input  lane_op_e     op,
  input  logic [W-1:0] fresh,
  input  logic [W-1:0] other,
  output logic [W-1:0] acc,
  output logic         ovf
);
  localparam int M = W - 1;

  logic [W-1:0] acc_q, acc_d, p, q, r;
  logic         ovf_q, ovf_d, wrap;

  always_comb begin
    p    = fb ? acc_q : fresh;
    q    = other;
    r    = '0;
    wrap = 1'b0;
    unique case (op)
      OP_ADD: begin
        r    = p + q;
        wrap = (p[M] == q[M]) && (r[M] != p[M]);
      end
      OP_PASS: begin
        r    = p;
        wrap = 1'b0;
      end
      OP_SUB: begin
        r    = p - q;
        wrap = (p[M] != q[M]) && (r[M] != p[M]);
      end
      OP_RSUB: begin
        r    = q - p;
        wrap = (q[M] != p[M]) && (r[M] != q[M]);
      end
      default: begin
        r    = '0;
        wrap = 1'b0;
      end
    endcase
    if (clr) begin
      acc_d = '0;
      ovf_d = 1'b0;
    end else begin
      acc_d = r;
      ovf_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/cplx_accum_dual.sv
module cplx_accum_dual
  import cad_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int ACC_W   = 20,
  parameter int DLY_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  a_in,
  input  logic [IN_W-1:0]  b_in,
  input  logic             a_load_n,
  input  logic             b_load_n,
  input  logic [1:0]       op_re,
  input  logic [1:0]       op_im,
  input  logic             fb_sel,
  input  logic             dly_sel,
  input  logic             acc_clr,
  input  logic             oe_re_n,
  input  logic             oe_im_n,
  output logic [ACC_W-1:0] acc_re,
  output logic [ACC_W-1:0] acc_im,
  output logic             ovf_re,
  output logic             ovf_im,
  output logic             oe_re_out_n,
  output logic             oe_im_out_n
);
  localparam int EXT_W = ACC_W - IN_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // input data registers with active-low loads
  logic [IN_W-1:0] a_q, a_d, b_q, b_d;
  always_comb begin
    a_d = a_load_n ? a_q : a_in;
    b_d = b_load_n ? b_q : b_in;
  end

  // control registers
  lane_op_e op_re_q, op_im_q, op_re_d, op_im_d;
  logic     fb_q, dly_q, clr_q;
  always_comb begin
    op_re_d = lane_op_e'(op_re);
    op_im_d = lane_op_e'(op_im);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      a_q     <= '0;
      b_q     <= '0;
      op_re_q <= OP_ADD;
      op_im_q <= OP_ADD;
      fb_q    <= 1'b0;
      dly_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      a_q     <= a_d;
      b_q     <= b_d;
      op_re_q <= op_re_d;
      op_im_q <= op_im_d;
      fb_q    <= fb_sel;
      dly_q   <= dly_sel;
      clr_q   <= acc_clr;
    end
  end

  // sign extension and deskew path
  logic [ACC_W-1:0] a_ext, b_ext, a_late, re_fresh;
  always_comb begin
    a_ext = {{EXT_W{a_q[IN_W-1]}}, a_q};
    b_ext = {{EXT_W{b_q[IN_W-1]}}, b_q};
  end

  cad_deskew #(.W(ACC_W), .DEPTH(DLY_LEN)) u_deskew (
    .clk  (clk),
    .rst_n(rst_sn),
    .din  (a_ext),
    .dout (a_late)
  );

  always_comb re_fresh = dly_q ? a_late : a_ext;

  cad_lane #(.W(ACC_W)) u_lane_re (
    .clk  (clk),
    .rst_n(rst_sn),
    .clr  (clr_q),
    .fb   (fb_q),
    .op   (op_re_q),
    .fresh(re_fresh),
    .other(b_ext),
    .acc  (acc_re),
    .ovf  (ovf_re)
  );

  cad_lane #(.W(ACC_W)) u_lane_im (
    .clk  (clk),
    .rst_n(rst_sn),
    .clr  (clr_q),
    .fb   (fb_q),
    .op   (op_im_q),
    .fresh(b_ext),
    .other(a_ext),
    .acc  (acc_im),
    .ovf  (ovf_im)
  );

  assign oe_re_out_n = oe_re_n;
  assign oe_im_out_n = oe_im_n;
endmodule

// File: rtl/cad_checker.sv
module cad_checker #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             clr_q,
  input logic             fb_q,
  input logic             dly_q,
  input logic [1:0]       op_re_q,
  input logic             a_load_n,
  input logic [IN_W-1:0]  a_q,
  input logic [IN_W-1:0]  b_q,
  input logic [ACC_W-1:0] acc_re,
  input logic [ACC_W-1:0] acc_im,
  input logic             ovf_re,
  input logic             ovf_im
);
  localparam int EXT_W = ACC_W - IN_W;

  // R7: a registered clear empties both lanes on the next edge
  p_clear_both_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_q |=> (acc_re == '0) && (acc_im == '0) && !ovf_re && !ovf_im);

  // R3: pass never flags a wrap
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_q && op_re_q == 2'b01) |=> !ovf_re);

  // R5: feedback plus pass keeps the real accumulator
  p_feedback_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_q && fb_q && op_re_q == 2'b01) |=> $stable(acc_re));

  // R9: a high load enable keeps the A register
  p_a_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    a_load_n |=> $stable(a_q));

  // R2: fresh add on the real lane
  p_fresh_add_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_q && !fb_q && !dly_q && op_re_q == 2'b00) |=>
      acc_re == ($past({{EXT_W{a_q[IN_W-1]}}, a_q}) + $past({{EXT_W{b_q[IN_W-1]}}, b_q})));
endmodule

bind cplx_accum_dual cad_checker #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .clr_q   (clr_q),
  .fb_q    (fb_q),
  .dly_q   (dly_q),
  .op_re_q (op_re_q),
  .a_load_n(a_load_n),
  .a_q     (a_q),
  .b_q     (b_q),
  .acc_re  (acc_re),
  .acc_im  (acc_im),
  .ovf_re  (ovf_re),
  .ovf_im  (ovf_im)
);

// File: tb/sim_cplx_accum_dual.sv
module sim_cplx_accum_dual;
  localparam int PERIOD = 10;
  localparam int IW = 16;
  localparam int AW = 20;
  localparam int DL = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] a_in, b_in;
  logic          a_load_n, b_load_n;
  logic [1:0]    op_re, op_im;
  logic          fb_sel, dly_sel, acc_clr, oe_re_n, oe_im_n;
  logic [AW-1:0] acc_re, acc_im;
  logic          ovf_re, ovf_im, oe_re_out_n, oe_im_out_n;

  always #(PERIOD/2) clk = ~clk;

  cplx_accum_dual u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_load_n(a_load_n), .b_load_n(b_load_n), .op_re(op_re), .op_im(op_im),
    .fb_sel(fb_sel), .dly_sel(dly_sel), .acc_clr(acc_clr),
    .oe_re_n(oe_re_n), .oe_im_n(oe_im_n), .acc_re(acc_re), .acc_im(acc_im),
    .ovf_re(ovf_re), .ovf_im(ovf_im),
    .oe_re_out_n(oe_re_out_n), .oe_im_out_n(oe_im_out_n)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [AW-1:0] re;
    logic [AW-1:0] im;
    logic          vr;
    logic          vi;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // model state: the registers as the requirements describe them
  logic [IW-1:0] m_a, m_b;
  logic [1:0]    m_ore, m_oim;
  logic          m_fb, m_dly, m_clr;
  logic [AW-1:0] m_hist [DL];
  logic [AW-1:0] m_re, m_im;

  function automatic logic [AW-1:0] sx(input logic [IW-1:0] v);
    return {{(AW-IW){v[IW-1]}}, v};
  endfunction

  // returns {wrap, result}, wrap from a 21-bit exact result
  function automatic logic [AW:0] alu(input logic [1:0] op,
                                      input logic [AW-1:0] p,
                                      input logic [AW-1:0] q);
    logic signed [AW:0] fp, fq, fr;
    fp = {p[AW-1], p};
    fq = {q[AW-1], q};
    case (op)
      2'b00:   fr = fp + fq;
      2'b01:   fr = fp;
      2'b10:   fr = fp - fq;
      default: fr = fq - fp;
    endcase
    return {fr[AW] != fr[AW-1], fr[AW-1:0]};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model_reset();
    m_a = '0; m_b = '0; m_ore = 2'b00; m_oim = 2'b00;
    m_fb = 1'b0; m_dly = 1'b0; m_clr = 1'b0; m_re = '0; m_im = '0;
    for (int i = 0; i < DL; i++) m_hist[i] = '0;
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic [IW-1:0] a, input logic [IW-1:0] b,
                       input logic la_n, input logic lb_n,
                       input logic [1:0] ore, input logic [1:0] oim,
                       input logic fb, input logic dly, input logic clr,
                       input string tag);
    exp_t e;
    logic [AW:0] rr, ri;
    logic [AW-1:0] pr, pi;
    @(negedge clk);
    a_in = a; b_in = b; a_load_n = la_n; b_load_n = lb_n;
    op_re = ore; op_im = oim; fb_sel = fb; dly_sel = dly; acc_clr = clr;
    pr = m_fb ? m_re : (m_dly ? m_hist[DL-1] : sx(m_a));
    pi = m_fb ? m_im : sx(m_b);
    rr = alu(m_ore, pr, sx(m_b));
    ri = alu(m_oim, pi, sx(m_a));
    if (m_clr) begin rr = '0; ri = '0; end
    e.re = rr[AW-1:0]; e.im = ri[AW-1:0]; e.vr = rr[AW]; e.vi = ri[AW];
    e.tag = tag;
    sb.push_back(e);
    m_re = e.re; m_im = e.im;
    for (int i = DL-1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = sx(m_a);
    if (!la_n) m_a = a;
    if (!lb_n) m_b = b;
    m_ore = ore; m_oim = oim; m_fb = fb; m_dly = dly; m_clr = clr;
  endtask

  // monitor: compares each edge's result with the queued item
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (acc_re !== e.re || acc_im !== e.im || ovf_re !== e.vr || ovf_im !== e.vi) begin
        n_fail++;
        $display("FAIL %s actual=%h/%h/%b%b expected=%h/%h/%b%b", e.tag,
                 acc_re, acc_im, ovf_re, ovf_im, e.re, e.im, e.vr, e.vi);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0; a_load_n = 1'b1; b_load_n = 1'b1;
    op_re = 2'b00; op_im = 2'b00; fb_sel = 1'b0; dly_sel = 1'b0;
    acc_clr = 1'b0; oe_re_n = 1'b1; oe_im_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 acc_re", acc_re, '0);
    check("R1 acc_im", acc_im, '0);
    check("R1 ovf", {18'd0, ovf_re, ovf_im}, '0);
    // R11: enables pass through
    check("R11 oe_re", {19'd0, oe_re_out_n}, 20'd1);
    oe_re_n = 1'b0; oe_im_n = 1'b1; #1;
    check("R11 oe_im", {18'd0, oe_re_out_n, oe_im_out_n}, 20'd1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: deskew line is zero after reset
    for (int i = 0; i < 4; i++)
      drive(16'd500 + 16'(i), 16'd7, 1'b0, 1'b0, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, "R6 zero");
    // R2 / R4: each operation code, lanes on different codes
    drive(16'd100, 16'd30, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R2 R4 add");
    drive(16'd100, 16'd30, 1'b0, 1'b0, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, "R2 R4 pass");
    drive(16'd100, 16'd30, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, "R2 R4 sub");
    drive(16'd100, 16'd30, 1'b0, 1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, "R2 R4 rsub");
    // R10: negative inputs
    drive(16'hFFFB, 16'd3, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R10 neg");
    drive(16'h8000, 16'h8000, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R10 min");
    // R9: loads held high keep old data
    drive(16'd1234, 16'd4321, 1'b1, 1'b1, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R9 hold");
    drive(16'd1234, 16'd9, 1'b1, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, "R9 b only");
    drive(16'd1234, 16'd9, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R9 a only");
    // R8: controls toggle every cycle, data aligned
    for (int i = 0; i < 6; i++)
      drive(16'(i * 11), 16'(i * 3 + 1), 1'b0, 1'b0, 2'(i), 2'(3 - i), 1'b0, 1'(i % 2), 1'b0, "R8 align");
    // R6: delayed A path with a gap in A loads
    for (int i = 0; i < 14; i++)
      drive(16'(40 + i), 16'd2, (i == 5) ? 1'b1 : 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, "R6 delay");
    // R7: clear before accumulation
    drive(16'd0, 16'h7FFF, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, "R7 clear");
    // R5 / R3: accumulate full scale until both lanes wrap
    for (int i = 0; i < 20; i++)
      drive(16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b0, "R5 R3 accum");
    drive(16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, "R5 R3 pass");
    drive(16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0, 1'b1, "R7 clear flags");
    drive(16'd5, 16'd6, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, "R7 cleared");
    drive(16'd5, 16'd6, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R5 after");
    drive(16'd5, 16'd6, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, "R2 tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule